// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Controller

This block connects a simple register bus to a one-time-programmable fuse array. When reset is released, a boot sequencer copies the first eight fuse words into shadow registers. Software can then read that configuration without touching the array. While the copy runs, a 4-bit state field in a status register shows a busy code. It shows 0xF once the controller is idle.

After boot, software can run single array reads, either a full 32-bit word or a zero-extended 16-bit half-word. It can also blow one fuse bit at a time. Programming must be unlocked by two enable bits together. A counter register sets the length of the program strobe in clock cycles. Each kind of operation sets its own done flag, and each flag is cleared by a write-one-to-clear register.

The sequence for one operation is fixed:
1. Software writes the request.
2. It polls the done flag, or waits for `irq_o`.
3. It clears the flag.
4. It writes the request bit back to 0, which re-arms that request.

Top module: `otp_access_ctrl`

Register map (word index on `bus_addr_i`):
- 0: control. Bit 0 is the global enable; bit 1 is the program enable.
- 1: read control. Bit 0 is the request, bit 1 the mode, bits [13:8] the address.
- 2: program control. Bit 0 is the request; bits [17:8] are the fuse bit address.
- 3: pulse control. Bits [15:8] hold the strobe width TPP.
- 4: interrupt status. Bit 0 is read-done; bit 1 is program-done.
- 5: interrupt clear.
- 6: read value.
- 7: status. Bits [3:0] hold the state code.
- 8 to 15: shadow words 0 to 7.

## Requirements
- R1: After reset the state field (register 7, bits [3:0]) reads 0x1 while fuse words 0..7 are copied. It then reads 0xF, and registers 8..15 return array words 0..7 in that order.
- R2: Bus writes to the status, read-value, interrupt-status and shadow registers (4, 6, 7, 8..15) change nothing.
- R3: A read with mode bit 1 returns the full 32-bit array word at word address bits [12:8]. It places the word in register 6 and sets interrupt status bit 0.
- R4: A read with mode bit 0 treats bits [13:8] as a half-word index. The word is the index shifted right by one, and index bit 0 selects the upper half. The 16 bits are returned zero-extended in register 6.
- R5: A read request is held off while the global enable (register 0, bit 0) is 0. No array read and no done flag occur. The read proceeds once the enable is set.
- R6: A program request is held off unless both register 0 bits 0 and 1 are set. The array stays unchanged until they are.
- R7: A program operation asserts `arr_prog_o` for exactly TPP cycles, with TPP taken from register 3 bits [15:8]; a TPP of 0 gives one cycle. During the strobe `arr_bit_o` carries the bit address, whose bits [9:5] select the word and bits [4:0] select the bit.
- R8: Program-done (interrupt status bit 1) becomes set on the cycle after `arr_prog_o` is released.
- R9: Writing 1 to bit 0 or bit 1 of register 5 clears only the matching status bit. `irq_o` is the OR of both status bits.
- R10: After an operation completes, its request bit must return to 0 before the same request type is accepted again.
- R11: A request that arrives while another operation is running waits until that operation ends. The state field reads 0x3 during programming and 0xF only when the controller is free.
- R12: The TPP field resets to 10 and reads back what was written, so software can update it with a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | OR of read-done and program-done |
| arr_rd_o | output | 1 | Array read strobe; data is expected on the next cycle |
| arr_addr_o | output | 5 | Array word address |
| arr_rdata_i | input | 32 | Array read data |
| arr_prog_o | output | 1 | Program strobe |
| arr_bit_o | output | 10 | Fuse bit address for programming |

## Verification
The hardest situations to reach are a read request that lands while a long program strobe is active, and a request bit left high after its operation finished. Both depend on exact ordering against the internal sequencer.

The bench reaches the first by setting a 40-cycle TPP and writing the read request a few cycles into the strobe. It then checks that the read completes only after program-done. It reaches the second by leaving the request bit set after completion and counting array read strobes over an idle window. A negedge monitor measures the strobe width and the distance from strobe release to the interrupt.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    ST_BOOT_ISS, ST_BOOT_CAP, ST_IDLE, ST_RD_ISS, ST_RD_CAP, ST_PG, ST_PG_END
  } seq_st_e;

  localparam logic [3:0] CODE_BOOT = 4'h1;
  localparam logic [3:0] CODE_RD   = 4'h2;
  localparam logic [3:0] CODE_PG   = 4'h3;
  localparam logic [3:0] CODE_IDLE = 4'hF;

  localparam int REG_CTRL   = 0;
  localparam int REG_RDCTL  = 1;
  localparam int REG_PGCTL  = 2;
  localparam int REG_PULSE  = 3;
  localparam int REG_ISTS   = 4;
  localparam int REG_ICLR   = 5;
  localparam int REG_RDVAL  = 6;
  localparam int REG_STS    = 7;
  localparam int SHADOW_BASE = 8;
  localparam int FIELD_LSB  = 8;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BOOT_WORDS = 8,
  parameter int TPP_W      = 8,
  localparam int BIT_W     = ADDR_W + 5,
  localparam int HA_W      = ADDR_W + 1,
  localparam int BIDX_W    = $clog2(BOOT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pen_i,
  input  logic              rd_req_i,
  input  logic              rd_mode_i,
  input  logic [HA_W-1:0]   rd_addr_i,
  input  logic              pg_req_i,
  input  logic [BIT_W-1:0]  pg_bit_i,
  input  logic [TPP_W-1:0]  tpp_i,
  output logic              arr_rd_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [31:0]       arr_rdata_i,
  output logic              arr_prog_o,
  output logic [BIT_W-1:0]  arr_bit_o,
  output logic              ld_we_o,
  output logic [BIDX_W-1:0] ld_idx_o,
  output logic              rv_we_o,
  output logic [31:0]       rv_data_o,
  output logic              rd_done_o,
  output logic              pg_done_o,
  output logic [3:0]        code_o
);
  seq_st_e            st_q;
  logic [BIDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0]  word_q;
  logic               hi_q, mode_q;
  logic [BIT_W-1:0]   bit_q;
  logic [TPP_W-1:0]   cnt_q;
  logic               rd_arm_q, pg_arm_q;
  logic               rd_go, pg_go;

  assign rd_go = (st_q == ST_IDLE) && en_i && rd_req_i && rd_arm_q;
  assign pg_go = (st_q == ST_IDLE) && en_i && pen_i && pg_req_i && pg_arm_q && !rd_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_BOOT_ISS;
      idx_q  <= '0;
      word_q <= '0;
      hi_q   <= 1'b0;
      mode_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_BOOT_ISS: st_q <= ST_BOOT_CAP;
        ST_BOOT_CAP: begin
          if (idx_q == BIDX_W'(BOOT_WORDS - 1)) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_BOOT_ISS;
          end
        end
        ST_IDLE: begin
          if (rd_go) begin
            st_q   <= ST_RD_ISS;
            mode_q <= rd_mode_i;
            if (rd_mode_i) begin
              word_q <= rd_addr_i[ADDR_W-1:0];
              hi_q   <= 1'b0;
            end else begin
              word_q <= rd_addr_i[HA_W-1:1];
              hi_q   <= rd_addr_i[0];
            end
          end else if (pg_go) begin
            st_q  <= ST_PG;
            bit_q <= pg_bit_i;
            cnt_q <= (tpp_i == '0) ? '0 : tpp_i - 1'b1;
          end
        end
        ST_RD_ISS: st_q <= ST_RD_CAP;
        ST_RD_CAP: st_q <= ST_IDLE;
        ST_PG: begin
          if (cnt_q == '0) st_q <= ST_PG_END;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_PG_END: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  // a request is re-armed only once software drops its request bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_arm_q <= 1'b1;
      pg_arm_q <= 1'b1;
    end else begin
      if (rd_go) rd_arm_q <= 1'b0;
      else if (!rd_req_i) rd_arm_q <= 1'b1;
      if (pg_go) pg_arm_q <= 1'b0;
      else if (!pg_req_i) pg_arm_q <= 1'b1;
    end
  end

  assign arr_rd_o   = (st_q == ST_BOOT_ISS) || (st_q == ST_RD_ISS);
  assign arr_addr_o = (st_q == ST_BOOT_ISS) ? ADDR_W'(idx_q) : word_q;
  assign arr_prog_o = (st_q == ST_PG);
  assign arr_bit_o  = bit_q;
  assign ld_we_o    = (st_q == ST_BOOT_CAP);
  assign ld_idx_o   = idx_q;
  assign rv_we_o    = (st_q == ST_RD_CAP);
  assign rv_data_o  = mode_q ? arr_rdata_i
                    : {16'h0000, (hi_q ? arr_rdata_i[31:16] : arr_rdata_i[15:0])};
  assign rd_done_o  = (st_q == ST_RD_CAP);
  assign pg_done_o  = (st_q == ST_PG_END);

  always_comb begin
    unique case (st_q)
      ST_BOOT_ISS, ST_BOOT_CAP: code_o = CODE_BOOT;
      ST_RD_ISS, ST_RD_CAP:     code_o = CODE_RD;
      ST_PG, ST_PG_END:         code_o = CODE_PG;
      default:                  code_o = CODE_IDLE;
    endcase
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BOOT_WORDS = 8,
  parameter int TPP_W      = 8,
  parameter logic [TPP_W-1:0] TPP_RST = 10,
  localparam int BIT_W     = ADDR_W + 5,
  localparam int HA_W      = ADDR_W + 1,
  localparam int BIDX_W    = $clog2(BOOT_WORDS),
  localparam int REG_AW    = $clog2(SHADOW_BASE + BOOT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              en_o,
  output logic              pen_o,
  output logic              rd_req_o,
  output logic              rd_mode_o,
  output logic [HA_W-1:0]   rd_addr_o,
  output logic              pg_req_o,
  output logic [BIT_W-1:0]  pg_bit_o,
  output logic [TPP_W-1:0]  tpp_o,
  output logic              pg_sts_o,
  input  logic              ld_we_i,
  input  logic [BIDX_W-1:0] ld_idx_i,
  input  logic [31:0]       ld_data_i,
  input  logic              rv_we_i,
  input  logic [31:0]       rv_data_i,
  input  logic              rd_done_i,
  input  logic              pg_done_i,
  input  logic [3:0]        code_i
);
  logic [31:0] shadow_q [BOOT_WORDS];
  logic [31:0] rval_q;
  logic        rd_sts_q, pg_sts_q;
  logic        wr;
  logic [REG_AW-1:0] sidx;

  assign wr   = bus_sel_i && bus_we_i;
  assign sidx = bus_addr_i - REG_AW'(SHADOW_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      pen_o     <= 1'b0;
      rd_req_o  <= 1'b0;
      rd_mode_o <= 1'b0;
      rd_addr_o <= '0;
      pg_req_o  <= 1'b0;
      pg_bit_o  <= '0;
      tpp_o     <= TPP_RST;
    end else if (wr) begin
      unique case (int'(bus_addr_i))
        REG_CTRL: begin
          en_o  <= bus_wdata_i[0];
          pen_o <= bus_wdata_i[1];
        end
        REG_RDCTL: begin
          rd_req_o  <= bus_wdata_i[0];
          rd_mode_o <= bus_wdata_i[1];
          rd_addr_o <= bus_wdata_i[FIELD_LSB +: HA_W];
        end
        REG_PGCTL: begin
          pg_req_o <= bus_wdata_i[0];
          pg_bit_o <= bus_wdata_i[FIELD_LSB +: BIT_W];
        end
        REG_PULSE: tpp_o <= bus_wdata_i[FIELD_LSB +: TPP_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BOOT_WORDS; i++) shadow_q[i] <= '0;
      rval_q   <= '0;
      rd_sts_q <= 1'b0;
      pg_sts_q <= 1'b0;
    end else begin
      if (ld_we_i) shadow_q[ld_idx_i] <= ld_data_i;
      if (rv_we_i) rval_q <= rv_data_i;
      // set wins over a simultaneous clear
      rd_sts_q <= rd_done_i | (rd_sts_q & ~(wr && int'(bus_addr_i) == REG_ICLR && bus_wdata_i[0]));
      pg_sts_q <= pg_done_i | (pg_sts_q & ~(wr && int'(bus_addr_i) == REG_ICLR && bus_wdata_i[1]));
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (int'(bus_addr_i))
      REG_CTRL:  bus_rdata_o[1:0] = {pen_o, en_o};
      REG_RDCTL: begin
        bus_rdata_o[1:0] = {rd_mode_o, rd_req_o};
        bus_rdata_o[FIELD_LSB +: HA_W] = rd_addr_o;
      end
      REG_PGCTL: begin
        bus_rdata_o[0] = pg_req_o;
        bus_rdata_o[FIELD_LSB +: BIT_W] = pg_bit_o;
      end
      REG_PULSE: bus_rdata_o[FIELD_LSB +: TPP_W] = tpp_o;
      REG_ISTS:  bus_rdata_o[1:0] = {pg_sts_q, rd_sts_q};
      REG_RDVAL: bus_rdata_o = rval_q;
      REG_STS:   bus_rdata_o[3:0] = code_i;
      default: begin
        if (bus_addr_i >= REG_AW'(SHADOW_BASE) && sidx < REG_AW'(BOOT_WORDS))
          bus_rdata_o = shadow_q[sidx[BIDX_W-1:0]];
      end
    endcase
  end

  assign irq_o    = rd_sts_q | pg_sts_q;
  assign pg_sts_o = pg_sts_q;
endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BOOT_WORDS = 8,
  parameter int TPP_W      = 8,
  parameter logic [TPP_W-1:0] TPP_RST = 10,
  localparam int BIT_W     = ADDR_W + 5,
  localparam int HA_W      = ADDR_W + 1,
  localparam int BIDX_W    = $clog2(BOOT_WORDS),
  localparam int REG_AW    = $clog2(SHADOW_BASE + BOOT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              arr_rd_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [31:0]       arr_rdata_i,
  output logic              arr_prog_o,
  output logic [BIT_W-1:0]  arr_bit_o
);
  logic              en_w, pen_w, rd_req_w, rd_mode_w, pg_req_w, pg_sts_w;
  logic [HA_W-1:0]   rd_addr_w;
  logic [BIT_W-1:0]  pg_bit_w;
  logic [TPP_W-1:0]  tpp_w;
  logic              ld_we_w, rv_we_w, rd_done_w, pg_done_w;
  logic [BIDX_W-1:0] ld_idx_w;
  logic [31:0]       ld_data_w, rv_data_w;
  logic [3:0]        code_w;

  assign ld_data_w = arr_rdata_i;

  otp_regs #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .TPP_W(TPP_W), .TPP_RST(TPP_RST)
  ) u_regs (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .irq_o,
    .en_o(en_w), .pen_o(pen_w), .rd_req_o(rd_req_w), .rd_mode_o(rd_mode_w),
    .rd_addr_o(rd_addr_w), .pg_req_o(pg_req_w), .pg_bit_o(pg_bit_w), .tpp_o(tpp_w),
    .pg_sts_o(pg_sts_w),
    .ld_we_i(ld_we_w), .ld_idx_i(ld_idx_w), .ld_data_i(ld_data_w),
    .rv_we_i(rv_we_w), .rv_data_i(rv_data_w),
    .rd_done_i(rd_done_w), .pg_done_i(pg_done_w), .code_i(code_w)
  );

  otp_seq #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .TPP_W(TPP_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .en_i(en_w), .pen_i(pen_w), .rd_req_i(rd_req_w), .rd_mode_i(rd_mode_w),
    .rd_addr_i(rd_addr_w), .pg_req_i(pg_req_w), .pg_bit_i(pg_bit_w), .tpp_i(tpp_w),
    .arr_rd_o, .arr_addr_o, .arr_rdata_i, .arr_prog_o, .arr_bit_o,
    .ld_we_o(ld_we_w), .ld_idx_o(ld_idx_w), .rv_we_o(rv_we_w), .rv_data_o(rv_data_w),
    .rd_done_o(rd_done_w), .pg_done_o(pg_done_w), .code_o(code_w)
  );
endmodule

// File: rtl/otp_access_ctrl_chk.sv
module otp_access_ctrl_chk #(
  parameter int BIT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arr_rd_o,
  input logic             arr_prog_o,
  input logic [BIT_W-1:0] arr_bit_o,
  input logic             en_w,
  input logic             pen_w,
  input logic             pg_sts_w,
  input logic [3:0]       code_w
);
  a_r11_exclusive_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_rd_o && arr_prog_o));

  a_r6_prog_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_prog_o) |-> $past(en_w && pen_w));

  a_r7_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_prog_o && $past(arr_prog_o)) |-> $stable(arr_bit_o));

  a_r8_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_prog_o) |=> pg_sts_w);

  a_r5_read_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o && code_w == 4'h2) |-> $past(en_w));
endmodule

bind otp_access_ctrl otp_access_ctrl_chk #(.BIT_W(BIT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arr_rd_o(arr_rd_o), .arr_prog_o(arr_prog_o),
  .arr_bit_o(arr_bit_o), .en_w(en_w), .pen_w(pen_w), .pg_sts_w(pg_sts_w),
  .code_w(code_w)
);

// File: tb/otp_access_ctrl_tb.sv
`timescale 1ns/1ps
module otp_access_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        arr_rd, arr_prog;
  logic [4:0]  arr_addr;
  logic [31:0] arr_rdata = '0;
  logic [9:0]  arr_bit;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [31:0] fmem [32];
  logic [31:0] gold [32];

  // monitor state
  int cyc = 0, run = 0, last_width = 0, fall_cyc = 0, irq_rise_cyc = 0;
  int strobes = 0, rd_pulses = 0;
  logic irq_prev = 1'b0;

  always #2.5 clk = ~clk;

  otp_access_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq),
    .arr_rd_o(arr_rd), .arr_addr_o(arr_addr), .arr_rdata_i(arr_rdata),
    .arr_prog_o(arr_prog), .arr_bit_o(arr_bit)
  );

  // behavioural fuse array: one-cycle read latency, bits only ever set
  always @(posedge clk) begin
    if (arr_rd) arr_rdata <= fmem[arr_addr];
    if (arr_prog) fmem[arr_bit[9:5]][arr_bit[4:0]] <= 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (arr_rd) rd_pulses <= rd_pulses + 1;
    if (arr_prog) begin
      if (run == 0) strobes <= strobes + 1;
      run <= run + 1;
    end else if (run > 0) begin
      last_width <= run;
      run <= 0;
      fall_cyc <= cyc;
    end
    if (irq && !irq_prev) irq_rise_cyc <= cyc;
    irq_prev <= irq;
  end

  function automatic logic [31:0] init_word(int i);
    return (32'h9E3779B9 * (i + 1)) ^ (32'h00FF00F0 >> (i % 7)) & 32'h7FFF7FFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic poll(input int b, input int lim, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      rd(4'd4, s);
      if (s[b]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_read(input string tag, input int fld, input bit mode, output logic [31:0] v);
    bit ok;
    wr(4'd1, (32'(fld) << 8) | (32'(mode) << 1) | 32'd1);
    poll(0, 100, ok);
    chk({tag, " done"}, 32'(ok), 32'd1);
    rd(4'd6, v);
    wr(4'd5, 32'd1);
    wr(4'd1, 32'd0);
  endtask

  task automatic set_tpp(input int tpp);
    logic [31:0] r;
    rd(4'd3, r);
    r[15:8] = 8'(tpp);
    wr(4'd3, r);
  endtask

  task automatic do_prog(input int b, input int tpp);
    bit ok;
    logic [31:0] v;
    set_tpp(tpp);
    wr(4'd0, 32'd3);
    wr(4'd2, (32'(b) << 8) | 32'd1);
    poll(1, 400, ok);
    chk("R8 prog done", 32'(ok), 32'd1);
    repeat (2) @(negedge clk);
    chk("R7 strobe width", 32'(last_width), 32'((tpp == 0) ? 1 : tpp));
    chk("R8 irq one cycle after release", 32'(irq_rise_cyc), 32'(fall_cyc + 1));
    wr(4'd5, 32'd2);
    wr(4'd2, 32'd0);
    gold[b >> 5][b & 31] = 1'b1;
    do_read("R7 programmed bit", b >> 5, 1'b1, v);
    chk("R7 word after program", v, gold[b >> 5]);
  endtask

  initial begin
    logic [31:0] v, s;
    bit ok;
    int n0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin
      fmem[i] = init_word(i);
      gold[i] = init_word(i);
    end
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    // R1 boot load
    rd(4'd7, v);
    chk("R1 boot code", v, 32'h1);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      rd(4'd7, v);
      if (v == 32'hF) begin ok = 1'b1; break; end
    end
    chk("R1 load finished", 32'(ok), 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), v);
      chk("R1 shadow word", v, gold[i]);
    end
    rd(4'd4, v);
    chk("R9 status after reset", v, 32'd0);
    chk("R9 irq after reset", 32'(irq), 32'd0);

    // R12 pulse field
    rd(4'd3, v);
    chk("R12 tpp reset", v, 32'd10 << 8);
    set_tpp(7);
    rd(4'd3, v);
    chk("R12 tpp readback", v, 32'd7 << 8);

    // R2 read-only registers
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, v);
    chk("R2 shadow write ignored", v, gold[1]);
    wr(4'd7, 32'h0);
    rd(4'd7, v);
    chk("R2 status write ignored", v, 32'hF);
    wr(4'd4, 32'h3);
    rd(4'd4, v);
    chk("R2 int status write ignored", v, 32'h0);

    // R5 read held off without enable
    wr(4'd0, 32'd0);
    n0 = rd_pulses;
    wr(4'd1, (32'd3 << 8) | 32'd3);
    repeat (20) @(negedge clk);
    rd(4'd4, v);
    chk("R5 no done without enable", v, 32'd0);
    chk("R5 no array read", 32'(rd_pulses), 32'(n0));
    wr(4'd0, 32'd1);
    poll(0, 100, ok);
    chk("R5 read after enable", 32'(ok), 32'd1);
    rd(4'd6, v);
    chk("R5 value", v, gold[3]);

    // R10 request must drop before re-accept
    wr(4'd5, 32'd1);
    n0 = rd_pulses;
    repeat (15) @(negedge clk);
    rd(4'd4, v);
    chk("R10 no repeat read done", v, 32'd0);
    chk("R10 no repeat array read", 32'(rd_pulses), 32'(n0));
    wr(4'd1, 32'd0);
    do_read("R10 rearmed", 3, 1'b1, v);
    chk("R10 rearmed value", v, gold[3]);

    // R3 random word reads
    for (int k = 0; k < 6; k++) begin
      int a = int'($urandom_range(31, 0));
      do_read("R3 word", a, 1'b1, v);
      chk("R3 word value", v, gold[a]);
    end
    // R4 half-word reads, directed ends plus random
    for (int k = 0; k < 8; k++) begin
      int h = (k == 0) ? 0 : (k == 1) ? 63 : int'($urandom_range(63, 0));
      logic [31:0] w;
      w = gold[h >> 1];
      do_read("R4 half", h, 1'b0, v);
      chk("R4 half value", v, (h & 1) ? {16'h0, w[31:16]} : {16'h0, w[15:0]});
    end

    // R6 program held off with only global enable
    set_tpp(3);
    wr(4'd0, 32'd1);
    n0 = strobes;
    wr(4'd2, (32'd37 << 8) | 32'd1);
    repeat (20) @(negedge clk);
    chk("R6 no strobe without prog enable", 32'(strobes), 32'(n0));
    rd(4'd4, v);
    chk("R6 no prog done", v, 32'd0);
    wr(4'd0, 32'd3);
    poll(1, 100, ok);
    chk("R6 program after enable", 32'(ok), 32'd1);
    wr(4'd5, 32'd2);
    wr(4'd2, 32'd0);
    gold[1][5] = 1'b1;
    do_read("R6 check", 1, 1'b1, v);
    chk("R6 bit blown", v, gold[1]);

    // R7 / R8 programs: directed tpp 0 and 1, then random
    do_prog(0, 0);
    do_prog(1023, 1);
    for (int k = 0; k < 4; k++)
      do_prog(int'($urandom_range(1023, 0)), int'($urandom_range(12, 2)));

    // R11 read arriving during a long strobe, R9 clears
    set_tpp(40);
    wr(4'd0, 32'd3);
    wr(4'd2, (32'd200 << 8) | 32'd1);
    repeat (3) @(negedge clk);
    rd(4'd7, v);
    chk("R11 program code", v, 32'h3);
    wr(4'd1, (32'd6 << 8) | 32'd3);
    repeat (5) @(negedge clk);
    rd(4'd4, v);
    chk("R11 read held during program", v, 32'd0);
    poll(1, 200, ok);
    chk("R11 program completes", 32'(ok), 32'd1);
    poll(0, 50, ok);
    chk("R11 read completes after", 32'(ok), 32'd1);
    gold[6][8] = 1'b1;
    rd(4'd6, v);
    chk("R11 read value", v, gold[6]);
    rd(4'd4, v);
    chk("R9 both set", v, 32'd3);
    wr(4'd5, 32'd2);
    rd(4'd4, v);
    chk("R9 clear prog only", v, 32'd1);
    chk("R9 irq still high", 32'(irq), 32'd1);
    wr(4'd5, 32'd1);
    rd(4'd4, v);
    chk("R9 clear read", v, 32'd0);
    chk("R9 irq low", 32'(irq), 32'd0);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'd0);
    rd(4'd7, s);
    chk("R11 idle code", s, 32'hF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule